// File: doc/BRIEF.md
# Sixteen-Way Condition Code Evaluator

This block decides whether a conditional instruction takes effect. It receives the low byte of the processor status register and a 4-bit condition field taken from the instruction. It drives a single "condition true" bit. It covers the usual carry, zero, sign and signed-compare tests. It also covers three tests specific to signal processing: an extension test, a limit test and a normalized-state test.

The condition field has a fixed layout. Its top bit selects the complementary form of the test named by the lower three bits. The block only interprets flags; it does not produce them.

An optional output register, selected by a parameter, retimes the decision by one clock. With the register enabled, the output clears on a synchronous active-low reset.

Top module: `cc_eval`

## Requirements
- R1: With REG_OUT=1, while `rst_n` is low at a rising clock edge, `take_o` is 0 after that edge, whatever the inputs.
- R2: With REG_OUT=1 (default), `take_o` shows the decision for the `status_i`/`cond_i` values present at the previous rising edge. With REG_OUT=0, the decision is purely combinational.
- R3: Status bits are read from bit 7 down to bit 0 as: sign-extension S, limit L, extension E, unnormalized U, negative N, zero Z, overflow V, carry C.
- R4: Code 4'b0000 (carry clear) is true when C=0. Code 4'b1000 (carry set) is true when C=1.
- R5: Code 4'b0010 (not equal) is true when Z=0. Code 4'b1010 (equal) is true when Z=1.
- R6: Code 4'b0011 (plus) is true when N=0. Code 4'b1011 (minus) is true when N=1.
- R7: Code 4'b0001 (greater or equal) is true when N XOR V = 0. Code 4'b1001 (less than) is true when N XOR V = 1.
- R8: Code 4'b0111 (greater than) is true when Z OR (N XOR V) = 0. Code 4'b1111 (less or equal) is true when that term is 1.
- R9: Code 4'b1100 (normalized) is true when Z OR (NOT U AND NOT E) = 1. Code 4'b0100 (not normalized) is true when that term is 0.
- R10: Code 4'b0101 (extension clear) is true when E=0, and 4'b1101 when E=1. Code 4'b0110 (limit clear) is true when L=0, and 4'b1110 when L=1.
- R11: For every status value and every k in 0..7, codes k and k+8 give opposite results.
- R12: Status bit 7 (S) has no effect on the result for any code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| status_i | input | 8 | Low byte of the status register |
| cond_i | input | 4 | Condition field of the instruction |
| take_o | output | 1 | High when the selected condition holds |

## Verification
A wrong flag tap or a swapped code row shows up as a wrong `take_o`. It appears one clock after the offending status/code pair is applied, or at once when the register is bypassed. The full sweep of every status byte against every code exposes such an error within the first pass. A fault in the polarity path breaks the pairing of code k with code k+8 across all status values. A fault in the output register or reset appears as a nonzero or stale `take_o` on the first edge after the inputs change.

// File: rtl/cc_pkg.sv
// Package: shared types for the condition code evaluator.
// Assumes the status byte order S L E U N Z V C (bit 7 to bit 0).
package cc_pkg;

    localparam int STATUS_W = 8;
    localparam int COND_W   = 4;
    localparam int SEL_W    = COND_W - 1;

    // Unpacked view of the status byte used by the evaluator.
    typedef struct packed {
        logic sx;   // sign extension (unused by tests)
        logic lim;  // limit
        logic ext;  // extension
        logic unn;  // unnormalized
        logic neg;  // negative
        logic zer;  // zero
        logic ovf;  // overflow
        logic cry;  // carry
    } flags_t;

    // Base tests selected by the three low bits of the condition field.
    typedef enum logic [SEL_W-1:0] {
        SEL_CARRY_CLR = 3'd0,
        SEL_GE        = 3'd1,
        SEL_NOT_ZERO  = 3'd2,
        SEL_PLUS      = 3'd3,
        SEL_NOT_NORM  = 3'd4,
        SEL_EXT_CLR   = 3'd5,
        SEL_LIM_CLR   = 3'd6,
        SEL_GT        = 3'd7
    } sel_t;

endpackage

// File: rtl/cc_flag_unpack.sv
// Module: cc_flag_unpack
// Splits the raw status byte into named flags.
// Assumes the fixed bit order S L E U N Z V C, bit 7 first.
module cc_flag_unpack
    import cc_pkg::*;
(
    input  logic [STATUS_W-1:0] status_i,
    output flags_t              flags_o
);

    // Purpose: map each status bit onto its named flag field.
    always_comb begin
        flags_o.sx  = status_i[7];
        flags_o.lim = status_i[6];
        flags_o.ext = status_i[5];
        flags_o.unn = status_i[4];
        flags_o.neg = status_i[3];
        flags_o.zer = status_i[2];
        flags_o.ovf = status_i[1];
        flags_o.cry = status_i[0];
    end

endmodule

// File: rtl/cc_base_eval.sv
// Module: cc_base_eval
// Evaluates the eight base tests, then applies the polarity bit.
// Assumes the polarity bit is the MSB of the condition field and that
// setting it selects the logical inverse of the base test.
module cc_base_eval
    import cc_pkg::*;
(
    input  flags_t            flags_i,
    input  logic [COND_W-1:0] cond_i,
    output logic              hit_o
);

    sel_t sel;
    logic inv;
    logic base;
    logic lt_term;
    logic le_term;
    logic norm_term;

    // Purpose: split the condition field into selector and polarity.
    always_comb begin
        sel = sel_t'(cond_i[SEL_W-1:0]);
        inv = cond_i[COND_W-1];
    end

    // Purpose: shared compare and normalization terms.
    always_comb begin
        lt_term   = flags_i.neg ^ flags_i.ovf;
        le_term   = flags_i.zer | lt_term;
        norm_term = flags_i.zer | (~flags_i.unn & ~flags_i.ext);
    end

    // Purpose: pick the base test named by the selector.
    always_comb begin
        unique case (sel)
            SEL_CARRY_CLR: base = ~flags_i.cry;
            SEL_GE:        base = ~lt_term;
            SEL_NOT_ZERO:  base = ~flags_i.zer;
            SEL_PLUS:      base = ~flags_i.neg;
            SEL_NOT_NORM:  base = ~norm_term;
            SEL_EXT_CLR:   base = ~flags_i.ext;
            SEL_LIM_CLR:   base = ~flags_i.lim;
            SEL_GT:        base = ~le_term;
            default:       base = 1'b0;
        endcase
    end

    // Purpose: apply the complement when the polarity bit is set.
    always_comb hit_o = base ^ inv;

endmodule

// File: rtl/cc_eval.sv
// Module: cc_eval (top)
// Decides whether a conditional instruction takes effect from the status
// byte and a 4-bit condition field. REG_OUT=1 adds one output register
// cleared by a synchronous active-low reset; REG_OUT=0 is combinational.
// Assumes flags are stable for the cycle they are sampled in.
module cc_eval
    import cc_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [STATUS_W-1:0] status_i,
    input  logic [COND_W-1:0]   cond_i,
    output logic                take_o
);

    flags_t flags;
    logic   hit;

    cc_flag_unpack u_unpack (
        .status_i (status_i),
        .flags_o  (flags)
    );

    cc_base_eval u_eval (
        .flags_i (flags),
        .cond_i  (cond_i),
        .hit_o   (hit)
    );

    generate
        if (REG_OUT) begin : g_reg
            logic take_q;
            // Purpose: retime the decision by one clock, clear on reset.
            always_ff @(posedge clk) begin
                if (!rst_n) take_q <= 1'b0;
                else        take_q <= hit;
            end
            assign take_o = take_q;
        end else begin : g_comb
            assign take_o = hit;
        end
    endgenerate

    // Port-level checks on the decision against the raw status bits.
    p_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_i == 4'b1000) |-> (hit == status_i[0]));
    p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_i == 4'b1010) |-> (hit == status_i[2]));
    p_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_i == 4'b0011) |-> (hit != status_i[3]));
    p_lt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_i == 4'b1001) |-> (hit == (status_i[3] != status_i[1])));
    p_le_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_i == 4'b1111 && status_i[2]) |-> hit);
    p_norm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_i == 4'b1100 && status_i[5:4] == 2'b00) |-> hit);
    p_limit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_i == 4'b1110) |-> (hit == status_i[6]));

endmodule

// File: tb/sim_cc_eval.sv
module sim_cc_eval;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] status_i = 8'h00;
    logic [3:0] cond_i = 4'h0;
    logic       take_o;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit res [256][16];

    always #2.5 clk = ~clk;   // 200 MHz

    cc_eval #(.REG_OUT(1'b1)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_i (status_i),
        .cond_i   (cond_i),
        .take_o   (take_o)
    );

    // Reference model written per full code from the requirement text.
    function automatic bit model(input logic [7:0] s, input logic [3:0] c);
        bit l = s[6], e = s[5], u = s[4], n = s[3], z = s[2], v = s[1], cy = s[0];
        case (c)
            4'b0000: return !cy;
            4'b1000: return cy;
            4'b0001: return (n ^ v) == 1'b0;
            4'b1001: return (n ^ v) == 1'b1;
            4'b0010: return !z;
            4'b1010: return z;
            4'b0011: return !n;
            4'b1011: return n;
            4'b0100: return (z | (!u & !e)) == 1'b0;
            4'b1100: return (z | (!u & !e)) == 1'b1;
            4'b0101: return !e;
            4'b1101: return e;
            4'b0110: return !l;
            4'b1110: return l;
            4'b0111: return (z | (n ^ v)) == 1'b0;
            default: return (z | (n ^ v)) == 1'b1;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] c);
        case (c[2:0])
            3'd0: return "R4";
            3'd1: return "R7";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R9";
            3'd7: return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string req, input bit act, input bit exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b status=%02h cond=%01h",
                     req, act, exp, status_i, cond_i);
        end
    endtask

    // Apply at a falling edge, register at the rising edge, sample at the next fall (R2).
    task automatic apply(input logic [7:0] s, input logic [3:0] c, output bit got);
        status_i = s;
        cond_i   = c;
        @(negedge clk);
        got = take_o;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit got;
        void'($urandom(32'd20240611));
        // R1: reset holds the output low even when the condition is true.
        @(negedge clk);
        status_i = 8'h04; cond_i = 4'b1010;   // equal with Z=1
        @(negedge clk);
        check("R1", take_o, 1'b0);
        @(negedge clk);
        check("R1", take_o, 1'b0);
        rst_n = 1'b1;
        // R2: one-cycle latency, output follows the previous edge's inputs.
        @(negedge clk);
        check("R2", take_o, 1'b1);
        status_i = 8'h00;
        #1;
        check("R2", take_o, 1'b1);            // not yet updated before the edge
        @(negedge clk);
        check("R2", take_o, 1'b0);
        // R3 directed: each flag alone against its own test.
        apply(8'h01, 4'b1000, got); check("R3", got, 1'b1);
        apply(8'h04, 4'b1010, got); check("R3", got, 1'b1);
        apply(8'h08, 4'b1011, got); check("R3", got, 1'b1);
        apply(8'h20, 4'b1101, got); check("R3", got, 1'b1);
        apply(8'h40, 4'b1110, got); check("R3", got, 1'b1);
        apply(8'h10, 4'b1100, got); check("R9", got, 1'b0); // U set, not zero
        apply(8'h02, 4'b1001, got); check("R7", got, 1'b1); // V only, less than
        apply(8'h0A, 4'b0111, got); check("R8", got, 1'b1); // N=V, Z=0, greater
        // Full sweep: every status value with every code.
        for (int s = 0; s < 256; s++) begin
            for (int c = 0; c < 16; c++) begin
                apply(s[7:0], c[3:0], got);
                res[s][c] = got;
                check(req_of(c[3:0]), got, model(s[7:0], c[3:0]));
            end
        end
        // R11 and R12 across the recorded sweep.
        for (int s = 0; s < 256; s++) begin
            for (int k = 0; k < 8; k++) begin
                total++;
                if (res[s][k] == res[s][k+8]) begin
                    bad++;
                    $display("FAIL R11: actual=%0b expected=%0b status=%02h code=%0d",
                             res[s][k+8], !res[s][k], s, k + 8);
                end
            end
            for (int c = 0; c < 16; c++) begin
                total++;
                if (res[s][c] != res[s ^ 8'h80][c]) begin
                    bad++;
                    $display("FAIL R12: actual=%0b expected=%0b status=%02h code=%0d",
                             res[s][c], res[s ^ 8'h80][c], s, c);
                end
            end
        end
        // Random pairs, back to back, against the model.
        for (int i = 0; i < 400; i++) begin
            logic [7:0] rs = 8'($urandom);
            logic [3:0] rc = 4'($urandom);
            apply(rs, rc, got);
            check(req_of(rc), got, model(rs, rc));
        end
        // R1 again mid-run: synchronous reset clears a true output.
        apply(8'h01, 4'b1000, got); check("R4", got, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", take_o, 1'b0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule